// File: doc/BRIEF.md
# Row Address Clock Timing Generator

This block paces a voice storage array through its rows during record and playback. Each row takes a fixed number of time-base ticks. The tick runs at eight times the sample rate. It comes either from an internal strobe or from an external clock, which is divided by two. Across each row the block drives a row marker that is high for seven eighths of the row and low for the last eighth. At the end of the row the row address steps to the next row. A cueing mode shrinks each row to a few ticks so that software can skip quickly through stored messages. When recording starts, the first high phase is stretched by one low-phase length so that the sampling circuits can settle.

A start strobe, together with the record or playback request, loads the starting row and begins the sequence. Sequencing stops when the last row finishes, which raises the overflow flag. During playback it also stops when the end-of-message input is found at a slot boundary, which raises the end-of-message flag. Each stop also produces a one-cycle event pulse for the interrupt logic. The tick counts and the row limit are parameters, so other sample rates and array sizes can be supported.

Top module: `row_clock_gen`

## Requirements
- R1: After reset `rac` is 1, `row_addr` is 0, and `ovf_flag`, `eom_flag`, `ovf_pulse` and `eom_pulse` are all 0.
- R2: A cycle with `start`=1 and either `rec_en` or `play_en` high loads `row_addr` from `start_row`, clears both flags and begins sequencing. A `start` with both requests low has no effect.
- R3: In normal rows `rac` stays 1 for the first HIGH_TICKS ticks of the row and 0 for the remaining ROW_TICKS-HIGH_TICKS ticks. On the tick that ends the row, `row_addr` increases by one and `rac` returns to 1.
- R4: Playback started with `cue_en`=1 uses rows of CUE_TICKS ticks, with `rac` high for the first CUE_HIGH of them. Record ignores `cue_en`.
- R5: The first row after a record start lasts ROW_TICKS plus ROW_TICKS-HIGH_TICKS ticks, with `rac` high for all but the last ROW_TICKS-HIGH_TICKS ticks. Later record rows, and all playback rows, are not stretched.
- R6: When the row NUM_ROWS-1 ends, sequencing stops, `row_addr` holds at NUM_ROWS-1, `ovf_flag` sets, `ovf_pulse` is high for exactly one cycle, and `rac` returns to 1.
- R7: In playback each row is cut into EOM_SLOTS equal slots. If `eom_mark` is 1 on the tick that ends a slot, sequencing stops, `eom_flag` sets and `eom_pulse` is high for one cycle. This takes priority over an overflow on the same tick.
- R8: During record `eom_mark` is ignored: the run ends only by overflow.
- R9: With USE_EXT_CLK=1 one tick is taken for every two rising edges of `xclk`, whatever its duty cycle. A cueing row then lasts 2*CUE_TICKS `xclk` periods.
- R10: Ticks that arrive while no run is active leave `row_addr` and `rac` unchanged.
- R11: A new valid `start` during a run restarts from the new `start_row` with a fresh row phase and the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_int | input | 1 | Internal time-base strobe (8x sample rate), used when USE_EXT_CLK=0 |
| xclk | input | 1 | External time-base clock, divided by two, used when USE_EXT_CLK=1 |
| start | input | 1 | Start strobe |
| rec_en | input | 1 | Record request (wins over playback) |
| play_en | input | 1 | Playback request |
| cue_en | input | 1 | Message-cueing rows for playback |
| start_row | input | ROW_W | Row loaded at start |
| eom_mark | input | 1 | End-of-message marker at the current slot |
| rac | output | 1 | Row marker, high outside the low phase and while stopped |
| row_addr | output | ROW_W | Current row address |
| ovf_flag | output | 1 | Memory end reached |
| eom_flag | output | 1 | End of message found in playback |
| ovf_pulse | output | 1 | One-cycle overflow event |
| eom_pulse | output | 1 | One-cycle end-of-message event |

## Verification
The assertions assume that `start_row` is always below NUM_ROWS, that `tick_int` is a one-cycle strobe, and that each level of `xclk` lasts at least one `clk` period so the synchroniser sees every rising edge. The bench keeps to these limits. It loads only legal start rows, draws the tick strobe one cycle at a time, and drives `xclk` with a one-cycle high pulse every six cycles. That irregular duty cycle also serves the divide-by-two check.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
   typedef enum logic [1:0] {
      RUN_IDLE = 2'd0,
      RUN_REC  = 2'd1,
      RUN_PLAY = 2'd2,
      RUN_CUE  = 2'd3
   } run_mode_e;
endpackage

// File: rtl/rcg_timebase.sv
module rcg_timebase #(
   parameter bit USE_EXT_CLK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_int,
   input  logic xclk,
   output logic tick
);
   generate
      if (USE_EXT_CLK) begin : g_ext
         logic [2:0] sync_q;
         logic       half_q;
         logic       rise;
         logic       unused_int;
         assign unused_int = tick_int;
         assign rise = sync_q[1] & ~sync_q[2];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
               half_q <= 1'b0;
            end else begin
               sync_q <= {sync_q[1:0], xclk};
               if (rise) half_q <= ~half_q;
            end
         end
         assign tick = rise & half_q;
      end else begin : g_int
         logic [2:0] unused_ext;
         assign unused_ext = {clk, rst_n, xclk};
         assign tick = tick_int;
      end
   endgenerate
endmodule

// File: rtl/rcg_phase.sv
module rcg_phase #(
   parameter int ROW_TICKS  = 12800,
   parameter int HIGH_TICKS = 11200,
   parameter int CUE_TICKS  = 8,
   parameter int CUE_HIGH   = 7,
   parameter int EOM_SLOTS  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   input  logic cue,
   input  logic stretch,
   output logic rac_hi,
   output logic row_end,
   output logic slot_end
);
   localparam int ROW_LOW  = ROW_TICKS - HIGH_TICKS;
   localparam int CUE_LOW  = CUE_TICKS - CUE_HIGH;
   localparam int LEN_NRM  = ROW_TICKS + ROW_LOW;
   localparam int LEN_CUE  = CUE_TICKS + CUE_LOW;
   localparam int MAX_LEN  = (LEN_NRM > LEN_CUE) ? LEN_NRM : LEN_CUE;
   localparam int LEN_W    = $clog2(MAX_LEN + 1);
   localparam int ROW_SLOT = ROW_TICKS / EOM_SLOTS;
   localparam int CUE_SLOT = CUE_TICKS / EOM_SLOTS;
   localparam int MAX_SLOT = (ROW_SLOT > CUE_SLOT) ? ROW_SLOT : CUE_SLOT;
   localparam int SLOT_W   = (MAX_SLOT < 2) ? 1 : $clog2(MAX_SLOT);

   logic [LEN_W-1:0]  pos_q;
   logic [LEN_W-1:0]  len_c, high_c, low_c;
   logic [SLOT_W-1:0] slot_q, slot_len;
   logic              slot_last, step;

   always_comb begin
      if (cue) begin
         len_c    = LEN_W'(CUE_TICKS);
         high_c   = LEN_W'(CUE_HIGH);
         low_c    = LEN_W'(CUE_LOW);
         slot_len = SLOT_W'(CUE_SLOT);
      end else begin
         len_c    = LEN_W'(ROW_TICKS);
         high_c   = LEN_W'(HIGH_TICKS);
         low_c    = LEN_W'(ROW_LOW);
         slot_len = SLOT_W'(ROW_SLOT);
      end
      if (stretch) begin
         len_c  = len_c + low_c;
         high_c = high_c + low_c;
      end
   end

   assign step      = tick & run;
   assign slot_last = (slot_q == slot_len - SLOT_W'(1));
   assign row_end   = step & (pos_q == len_c - LEN_W'(1));
   assign slot_end  = step & slot_last;
   assign rac_hi    = ~run | (pos_q < high_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         slot_q <= '0;
      end else if (clear) begin
         pos_q  <= '0;
         slot_q <= '0;
      end else if (step) begin
         pos_q  <= row_end ? '0 : pos_q + LEN_W'(1);
         slot_q <= (row_end | slot_last) ? '0 : slot_q + SLOT_W'(1);
      end
   end
endmodule

// File: rtl/rcg_row_ctrl.sv
module rcg_row_ctrl
   import rcg_pkg::*;
#(
   parameter int NUM_ROWS = 1200,
   parameter int ROW_W    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rec_en,
   input  logic             play_en,
   input  logic             cue_en,
   input  logic [ROW_W-1:0] start_row,
   input  logic             eom_mark,
   input  logic             row_end,
   input  logic             slot_end,
   output logic             clear,
   output logic             run,
   output logic             cue,
   output logic             stretch,
   output logic [ROW_W-1:0] row_addr,
   output logic             ovf_flag,
   output logic             eom_flag,
   output logic             ovf_pulse,
   output logic             eom_pulse
);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

   run_mode_e mode_q;
   logic      first_q;

   assign clear   = start & (rec_en | play_en);
   assign run     = (mode_q != RUN_IDLE);
   assign cue     = (mode_q == RUN_CUE);
   assign stretch = (mode_q == RUN_REC) & first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= RUN_IDLE;
         first_q   <= 1'b0;
         row_addr  <= '0;
         ovf_flag  <= 1'b0;
         eom_flag  <= 1'b0;
         ovf_pulse <= 1'b0;
         eom_pulse <= 1'b0;
      end else begin
         ovf_pulse <= 1'b0;
         eom_pulse <= 1'b0;
         if (clear) begin
            mode_q   <= rec_en ? RUN_REC : (cue_en ? RUN_CUE : RUN_PLAY);
            first_q  <= 1'b1;
            row_addr <= start_row;
            ovf_flag <= 1'b0;
            eom_flag <= 1'b0;
         end else if (run) begin
            if ((mode_q != RUN_REC) && slot_end && eom_mark) begin
               mode_q    <= RUN_IDLE;
               eom_flag  <= 1'b1;
               eom_pulse <= 1'b1;
            end else if (row_end) begin
               first_q <= 1'b0;
               if (row_addr == LAST_ROW) begin
                  mode_q    <= RUN_IDLE;
                  ovf_flag  <= 1'b1;
                  ovf_pulse <= 1'b1;
               end else begin
                  row_addr <= row_addr + ROW_W'(1);
               end
            end
         end
      end
   end
endmodule

// File: rtl/row_clock_gen.sv
module row_clock_gen #(
   parameter int  NUM_ROWS    = 1200,
   parameter int  ROW_TICKS   = 12800,
   parameter int  HIGH_TICKS  = 11200,
   parameter int  CUE_TICKS   = 8,
   parameter int  CUE_HIGH    = 7,
   parameter int  EOM_SLOTS   = 8,
   parameter bit  USE_EXT_CLK = 1'b0,
   localparam int ROW_W       = (NUM_ROWS < 2) ? 1 : $clog2(NUM_ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_int,
   input  logic             xclk,
   input  logic             start,
   input  logic             rec_en,
   input  logic             play_en,
   input  logic             cue_en,
   input  logic [ROW_W-1:0] start_row,
   input  logic             eom_mark,
   output logic             rac,
   output logic [ROW_W-1:0] row_addr,
   output logic             ovf_flag,
   output logic             eom_flag,
   output logic             ovf_pulse,
   output logic             eom_pulse
);
   generate
      if (NUM_ROWS < 2) begin : g_bad_rows
         $error("row_clock_gen: NUM_ROWS must be at least 2");
      end
      if (HIGH_TICKS < 1 || HIGH_TICKS >= ROW_TICKS) begin : g_bad_high
         $error("row_clock_gen: HIGH_TICKS must lie inside the row");
      end
      if (CUE_HIGH < 1 || CUE_HIGH >= CUE_TICKS) begin : g_bad_cue
         $error("row_clock_gen: CUE_HIGH must lie inside the cue row");
      end
      if ((ROW_TICKS % EOM_SLOTS) != 0 || (CUE_TICKS % EOM_SLOTS) != 0) begin : g_bad_slots
         $error("row_clock_gen: row lengths must divide into EOM_SLOTS");
      end
   endgenerate

   logic tick, clear, run, cue, stretch, rac_hi, row_end, slot_end;

   rcg_timebase #(.USE_EXT_CLK(USE_EXT_CLK)) u_tb (
      .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .xclk(xclk), .tick(tick)
   );

   rcg_phase #(
      .ROW_TICKS(ROW_TICKS), .HIGH_TICKS(HIGH_TICKS),
      .CUE_TICKS(CUE_TICKS), .CUE_HIGH(CUE_HIGH), .EOM_SLOTS(EOM_SLOTS)
   ) u_phase (
      .clk(clk), .rst_n(rst_n), .clear(clear), .run(run), .tick(tick),
      .cue(cue), .stretch(stretch), .rac_hi(rac_hi),
      .row_end(row_end), .slot_end(slot_end)
   );

   rcg_row_ctrl #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .rec_en(rec_en),
      .play_en(play_en), .cue_en(cue_en), .start_row(start_row),
      .eom_mark(eom_mark), .row_end(row_end), .slot_end(slot_end),
      .clear(clear), .run(run), .cue(cue), .stretch(stretch),
      .row_addr(row_addr), .ovf_flag(ovf_flag), .eom_flag(eom_flag),
      .ovf_pulse(ovf_pulse), .eom_pulse(eom_pulse)
   );

   assign rac = rac_hi;
endmodule

// File: rtl/rcg_checker.sv
module rcg_checker #(
   parameter int NUM_ROWS = 2,
   parameter int ROW_W    = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             rec_en,
   input logic             play_en,
   input logic             rac,
   input logic [ROW_W-1:0] row_addr,
   input logic             ovf_flag,
   input logic             eom_flag,
   input logic             ovf_pulse,
   input logic             eom_pulse
);
   logic rec_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec_seen <= 1'b0;
      else if (start && (rec_en || play_en)) rec_seen <= rec_en;
   end

   // R6: the row address never leaves the array
   p_row_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      row_addr <= ROW_W'(NUM_ROWS - 1));

   // R3: outside a start the row address only steps up by one
   p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(row_addr) && !$past(start)) |-> (row_addr == $past(row_addr) + ROW_W'(1)));

   // R6: overflow flag rises together with its event pulse, pulse lasts one cycle
   p_ovf_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> ovf_pulse);
   p_ovf_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);

   // R7: end-of-message flag rises with its pulse, never together with overflow
   p_eom_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eom_flag) |-> eom_pulse);
   p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_pulse && eom_pulse));

   // R8: no end-of-message event while recording
   p_no_eom_rec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      eom_pulse |-> !rec_seen);

   // R6, R7: a stopped sequencer releases the marker high
   p_stop_rac_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse || eom_pulse) |-> rac);
endmodule

bind row_clock_gen rcg_checker #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .rec_en(rec_en), .play_en(play_en),
   .rac(rac), .row_addr(row_addr), .ovf_flag(ovf_flag), .eom_flag(eom_flag),
   .ovf_pulse(ovf_pulse), .eom_pulse(eom_pulse)
);

// File: tb/tb_row_clock_gen.sv
`timescale 1ns/1ps
module tb_row_clock_gen;
   localparam int NR = 5, RT = 32, RH = 28, CT = 8, CH = 7, SL = 8;
   localparam int RW = 3;
   localparam int XPER = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_int = 1'b0, start = 1'b0, rec_en = 1'b0, play_en = 1'b0;
   logic cue_en = 1'b0, eom_mark = 1'b0;
   logic [RW-1:0] start_row = '0;
   logic rac, ovf_flag, eom_flag, ovf_pulse, eom_pulse;
   logic [RW-1:0] row_addr;

   logic xclk = 1'b0, x_start = 1'b0;
   logic x_rac, x_ovf, x_eom, x_op, x_ep;
   logic [RW-1:0] x_row;

   int checks = 0, fails = 0, cyc = 0, xcnt = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   row_clock_gen #(.NUM_ROWS(NR), .ROW_TICKS(RT), .HIGH_TICKS(RH), .CUE_TICKS(CT),
      .CUE_HIGH(CH), .EOM_SLOTS(SL), .USE_EXT_CLK(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .xclk(1'b0), .start(start),
      .rec_en(rec_en), .play_en(play_en), .cue_en(cue_en), .start_row(start_row),
      .eom_mark(eom_mark), .rac(rac), .row_addr(row_addr), .ovf_flag(ovf_flag),
      .eom_flag(eom_flag), .ovf_pulse(ovf_pulse), .eom_pulse(eom_pulse));

   row_clock_gen #(.NUM_ROWS(NR), .ROW_TICKS(RT), .HIGH_TICKS(RH), .CUE_TICKS(CT),
      .CUE_HIGH(CH), .EOM_SLOTS(SL), .USE_EXT_CLK(1'b1)) dut_x (
      .clk(clk), .rst_n(rst_n), .tick_int(1'b0), .xclk(xclk), .start(x_start),
      .rec_en(1'b0), .play_en(1'b1), .cue_en(1'b1), .start_row('0),
      .eom_mark(1'b0), .rac(x_rac), .row_addr(x_row), .ovf_flag(x_ovf),
      .eom_flag(x_eom), .ovf_pulse(x_op), .eom_pulse(x_ep));

   // external clock: one-cycle high pulse every XPER cycles
   always @(negedge clk) begin
      xcnt = (xcnt + 1) % XPER;
      xclk = (xcnt == 0);
   end

   // behavioural reference model
   int m_run, m_rec, m_cue, m_first, m_pos, m_row, m_ovf, m_eom, m_op, m_ep;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_rec = 0; m_cue = 0; m_first = 0; m_pos = 0;
         m_row = 0; m_ovf = 0; m_eom = 0; m_op = 0; m_ep = 0;
      end else begin
         m_op = 0; m_ep = 0;
         if (start && (rec_en || play_en)) begin
            m_run = 1; m_rec = rec_en; m_cue = cue_en && !rec_en; m_first = 1;
            m_row = start_row; m_pos = 0; m_ovf = 0; m_eom = 0;
         end else if (m_run && tick_int) begin
            int base, lo, len, slot;
            base = m_cue ? CT : RT;
            lo   = base - (m_cue ? CH : RH);
            len  = base + ((m_rec && m_first) ? lo : 0);
            slot = base / SL;
            if (!m_rec && ((m_pos + 1) % slot == 0) && eom_mark) begin
               m_run = 0; m_eom = 1; m_ep = 1;
            end else if (m_pos == len - 1) begin
               m_first = 0; m_pos = 0;
               if (m_row == NR - 1) begin m_run = 0; m_ovf = 1; m_op = 1; end
               else m_row++;
            end else m_pos++;
         end
      end
   end

   function automatic int exp_rac();
      int hi;
      hi = m_cue ? CH : RH;
      if (m_rec && m_first) hi += RT - RH;
      return (!m_run || m_pos < hi) ? 1 : 0;
   endfunction

   task automatic chk(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_all();
      chk(int'(rac), exp_rac(), cur_req, "rac");
      chk(int'(row_addr), m_row, cur_req, "row_addr");
      chk(int'(ovf_flag), m_ovf, cur_req, "ovf_flag");
      chk(int'(eom_flag), m_eom, cur_req, "eom_flag");
      chk(int'(ovf_pulse), m_op, cur_req, "ovf_pulse");
      chk(int'(eom_pulse), m_ep, cur_req, "eom_pulse");
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         summary();
      end
   end

   task automatic step();
      @(negedge clk);
      if (rst_n) check_all();
      tick_int = ($urandom % 4) != 0;
   endtask

   task automatic do_start(input bit rec, input bit play, input bit cue, input int row);
      rec_en = rec; play_en = play; cue_en = cue; start_row = RW'(row); start = 1'b1;
      step();
      start = 1'b0;
   endtask

   task automatic run_idle(input int lim);
      for (int i = 0; i < lim && m_run != 0; i++) step();
      step(); step();
   endtask

   initial begin
      int t0, t1;
      bit prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      @(negedge clk);
      chk(int'(rac), 1, "R1", "reset rac");
      chk(int'(row_addr), 0, "R1", "reset row_addr");
      chk(int'(ovf_flag | eom_flag | ovf_pulse | eom_pulse), 0, "R1", "reset flags");

      // R10: idle ticks change nothing
      cur_req = "R10";
      repeat (20) step();
      chk(int'(row_addr), 0, "R10", "idle row_addr");

      // R2: start without a request is ignored
      cur_req = "R2";
      do_start(0, 0, 0, 3);
      repeat (10) step();
      chk(int'(row_addr), 0, "R2", "ignored start row_addr");
      chk(int'(rac), 1, "R2", "ignored start rac");

      // R3, R6: normal playback to the end of memory
      cur_req = "R3";
      do_start(0, 1, 0, 1);
      chk(int'(row_addr), 1, "R2", "loaded start_row");
      run_idle(2000);
      chk(int'(ovf_flag), 1, "R6", "overflow flag");
      chk(int'(row_addr), NR - 1, "R6", "row held at last");

      // R5, R8: record with marker held high, first row stretched
      cur_req = "R5";
      eom_mark = 1'b1;
      do_start(1, 0, 1, 2);
      chk(int'(ovf_flag), 0, "R2", "flags cleared on start");
      run_idle(2000);
      chk(int'(eom_flag), 0, "R8", "record ignores eom_mark");
      chk(int'(ovf_flag), 1, "R8", "record ends by overflow");
      eom_mark = 1'b0;

      // R4: cueing playback through overflow
      cur_req = "R4";
      do_start(0, 1, 1, 0);
      run_idle(2000);
      chk(int'(ovf_flag), 1, "R4", "cue run overflow");

      // R7: marker found during normal playback
      cur_req = "R7";
      do_start(0, 1, 0, 0);
      repeat (45) step();
      eom_mark = 1'b1;
      run_idle(2000);
      eom_mark = 1'b0;
      chk(int'(eom_flag), 1, "R7", "eom flag set");
      chk(int'(ovf_flag), 0, "R7", "no overflow after eom");

      // R7: random markers in cue playback (includes slot end on row end)
      for (int k = 0; k < 6; k++) begin
         do_start(0, 1, k[0], k % NR);
         for (int i = 0; i < 400 && m_run != 0; i++) begin
            eom_mark = ($urandom % 12) == 0;
            step();
         end
         eom_mark = 1'b0;
         run_idle(2000);
      end

      // R11: restart during a run
      cur_req = "R11";
      do_start(0, 1, 0, 3);
      repeat (30) step();
      do_start(1, 0, 0, 0);
      chk(int'(row_addr), 0, "R11", "restart row");
      run_idle(3000);

      // R9: external clock, cue row period = 2*CT*XPER cycles
      cur_req = "R9";
      x_start = 1'b1; step(); x_start = 1'b0;
      prev = x_rac; t0 = -1; t1 = -1;
      for (int i = 0; i < 2000 && t1 < 0; i++) begin
         step();
         if (x_rac && !prev) begin
            if (t0 < 0) t0 = cyc; else t1 = cyc;
         end
         prev = x_rac;
      end
      chk(t1 - t0, 2 * CT * XPER, "R9", "external cue row period");
      chk(int'(x_row), 2, "R9", "external row advance");

      summary();
   end
endmodule